// File: doc/BRIEF.md
# Section Channel Ping-Pong Buffer

This block gathers the three section data-channel bytes that the receive path pulls from each frame and writes them into one of two register banks. A block is 24 accepted frames, which is 72 bytes. Two bytes go into each 16-bit word, so a bank holds 36 words. When the 24th frame of a block has been written, the two banks change roles. The bank just filled becomes the readable one, and the other bank starts to collect the next block. The processor therefore receives one interrupt per block and has a full block period to read the data.

The upstream frame logic gives a single-cycle strobe with the three bytes of a frame, listed in the order they arrived. Three alarm inputs (signal loss, frame loss, frame error) stop collection. While any alarm is high, a partly collected block is thrown away. Collection starts again from word 0 on the first strobe accepted after the alarms clear. A ready flag is set at every bank change and is cleared by a write-one pulse. The interrupt follows the ready flag unless it is masked.

Top module: `sect_chan_pingpong`

## Requirements
- R1: Bytes are packed two per word in arrival order across frames. Byte k of a block (k = 3*frame + position, position 0 = byte_a, 1 = byte_b, 2 = byte_c) goes to word k/2. It lands in bits [15:8] when k is even and in bits [7:0] when k is odd.
- R2: A bank change happens only on the 24th accepted frame strobe of a block. After 23 accepted strobes the ready flag is still 0.
- R3: Read addresses 0 to 35 always return the most recently completed bank. Writes into the collecting bank do not show on rd_data.
- R4: The ready flag is 1 in the cycle after the clock edge that takes the 24th strobe.
- R5: irq is 1 exactly when the ready flag is 1 and irq_mask is 0.
- R6: A pulse on rdy_clr clears the ready flag at the next edge. If the clear arrives in the same cycle as a bank change, the flag is set instead.
- R7: A strobe is ignored while any alarm input is 1. A partial block present when an alarm rises is discarded, so the next completed block holds only bytes received after the alarms clear.
- R8: After reset, rdy and irq are 0.
- R9: Read addresses 36 and above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse: the frame's channel bytes are valid |
| byte_a | input | 8 | First channel byte of the frame |
| byte_b | input | 8 | Second channel byte of the frame |
| byte_c | input | 8 | Third channel byte of the frame |
| alm_sig_loss | input | 1 | Signal-loss alarm |
| alm_frm_loss | input | 1 | Frame-loss alarm |
| alm_frm_err | input | 1 | Severely errored framing alarm |
| rd_addr | input | 6 | Word address into the readable bank |
| rd_data | output | 16 | Word read from the readable bank |
| rdy_clr | input | 1 | Write-one pulse that clears the ready flag |
| irq_mask | input | 1 | 1 masks the interrupt |
| rdy | output | 1 | Ready flag: a completed block is available |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that rdy_clr and the alarm inputs are synchronous to clk and held at 0 during reset. They also assume frame_stb is a clean one-cycle pulse. The bench drives every input on the falling edge and never holds frame_stb for more than one cycle. It keeps rdy_clr low during reset, so the checks that look at the previous cycle only ever see values that were actually driven.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int CHAN_BYTES = 3;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } pack_phase_e;
endpackage

// File: rtl/scp_fill_ctrl.sv
module scp_fill_ctrl
  import scp_pkg::*;
#(
  parameter int FRAMES = 24,
  parameter int AW     = 6,
  parameter int FCW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic          alarm_any,
  output logic          wr_en,
  output logic [AW-1:0] wr_ptr,
  output pack_phase_e   phase,
  output logic          fill_sel,
  output logic          swap_evt,
  output logic [FCW-1:0] frame_cnt
);
  logic [FCW-1:0] cnt_q, cnt_d;
  logic [AW-1:0]  ptr_q, ptr_d;
  pack_phase_e    ph_q, ph_d;
  logic           sel_q, sel_d;
  logic           accept, last;

  assign accept = frame_stb & ~alarm_any;
  assign last   = (cnt_q == FCW'(FRAMES - 1));

  always_comb begin
    cnt_d = cnt_q;
    ptr_d = ptr_q;
    ph_d  = ph_q;
    sel_d = sel_q;
    if (alarm_any) begin
      cnt_d = '0;
      ptr_d = '0;
      ph_d  = PH_EVEN;
    end else if (accept) begin
      if (last) begin
        cnt_d = '0;
        ptr_d = '0;
        ph_d  = PH_EVEN;
        sel_d = ~sel_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
        if (ph_q == PH_EVEN) begin
          ptr_d = ptr_q + AW'(1);
          ph_d  = PH_ODD;
        end else begin
          ptr_d = ptr_q + AW'(2);
          ph_d  = PH_EVEN;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
      ph_q  <= PH_EVEN;
      sel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ptr_q <= ptr_d;
      ph_q  <= ph_d;
      sel_q <= sel_d;
    end
  end

  assign wr_en     = accept;
  assign wr_ptr    = ptr_q;
  assign phase     = ph_q;
  assign fill_sel  = sel_q;
  assign swap_evt  = accept & last;
  assign frame_cnt = cnt_q;
endmodule

// File: rtl/scp_banks.sv
module scp_banks
  import scp_pkg::*;
#(
  parameter int WORDS = 36,
  parameter int AW    = 6,
  parameter int BW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          fill_sel,
  input  logic [AW-1:0] wr_ptr,
  input  pack_phase_e   phase,
  input  logic [BW-1:0] b0,
  input  logic [BW-1:0] b1,
  input  logic [BW-1:0] b2,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [2*BW-1:0] rd_data
);
  logic [2*BW-1:0] word_q [2][WORDS];
  logic [AW:0]     ptr_nx;
  logic            even;

  assign ptr_nx = {1'b0, wr_ptr} + (AW+1)'(1);
  assign even   = (phase == PH_EVEN);

  for (genvar bk = 0; bk < 2; bk++) begin : g_bank
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic          hit0, hit1, sel_ok;
      logic          hi_we, lo_we;
      logic [BW-1:0] hi_d, lo_d, hi_q, lo_q;

      assign sel_ok = wr_en & (fill_sel == bk[0]);
      assign hit0   = ({1'b0, wr_ptr} == (AW+1)'(w));
      assign hit1   = (ptr_nx == (AW+1)'(w));
      assign hi_we  = sel_ok & ((hit0 & even) | hit1);
      assign lo_we  = sel_ok & (hit0 | (hit1 & ~even));
      assign hi_d   = hit0 ? b0 : (even ? b2 : b1);
      assign lo_d   = hit0 ? (even ? b1 : b0) : b2;

      always_ff @(posedge clk) begin
        if (hi_we) hi_q <= hi_d;
      end

      always_ff @(posedge clk) begin
        if (lo_we) lo_q <= lo_d;
      end

      assign word_q[bk][w] = {hi_q, lo_q};
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < WORDS) rd_data = word_q[rd_sel][rd_addr];
  end
endmodule

// File: rtl/scp_status.sv
module scp_status (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_evt,
  input  logic rdy_clr,
  input  logic irq_mask,
  output logic rdy,
  output logic irq
);
  logic rdy_q, rdy_d;

  always_comb begin
    rdy_d = rdy_q;
    if (swap_evt)     rdy_d = 1'b1;
    else if (rdy_clr) rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  assign rdy = rdy_q;
  assign irq = rdy_q & ~irq_mask;
endmodule

// File: rtl/sect_chan_pingpong.sv
module sect_chan_pingpong
  import scp_pkg::*;
#(
  parameter int FRAMES = 24,
  parameter int BW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic [BW-1:0] byte_a,
  input  logic [BW-1:0] byte_b,
  input  logic [BW-1:0] byte_c,
  input  logic          alm_sig_loss,
  input  logic          alm_frm_loss,
  input  logic          alm_frm_err,
  input  logic [$clog2(CHAN_BYTES*FRAMES/2)-1:0] rd_addr,
  output logic [2*BW-1:0] rd_data,
  input  logic          rdy_clr,
  input  logic          irq_mask,
  output logic          rdy,
  output logic          irq
);
  localparam int WORDS = CHAN_BYTES * FRAMES / 2;
  localparam int AW    = $clog2(WORDS);
  localparam int FCW   = $clog2(FRAMES);

  logic           alarm_any;
  logic           wr_en, fill_sel, swap_evt;
  logic [AW-1:0]  wr_ptr;
  pack_phase_e    phase;
  logic [FCW-1:0] frame_cnt;

  assign alarm_any = alm_sig_loss | alm_frm_loss | alm_frm_err;

  scp_fill_ctrl #(.FRAMES(FRAMES), .AW(AW), .FCW(FCW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_stb(frame_stb),
    .alarm_any(alarm_any),
    .wr_en    (wr_en),
    .wr_ptr   (wr_ptr),
    .phase    (phase),
    .fill_sel (fill_sel),
    .swap_evt (swap_evt),
    .frame_cnt(frame_cnt)
  );

  scp_banks #(.WORDS(WORDS), .AW(AW), .BW(BW)) u_banks (
    .clk     (clk),
    .wr_en   (wr_en),
    .fill_sel(fill_sel),
    .wr_ptr  (wr_ptr),
    .phase   (phase),
    .b0      (byte_a),
    .b1      (byte_b),
    .b2      (byte_c),
    .rd_sel  (~fill_sel),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  scp_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .swap_evt(swap_evt),
    .rdy_clr (rdy_clr),
    .irq_mask(irq_mask),
    .rdy     (rdy),
    .irq     (irq)
  );
endmodule

// File: rtl/sect_chan_pingpong_chk.sv
module sect_chan_pingpong_chk #(
  parameter int FRAMES = 24,
  parameter int AW     = 6,
  parameter int FCW    = 5,
  parameter int DW     = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           alarm_any,
  input logic           swap_evt,
  input logic           fill_sel,
  input logic [FCW-1:0] frame_cnt,
  input logic           rdy_clr,
  input logic           irq_mask,
  input logic           rdy,
  input logic           irq,
  input logic [AW-1:0]  rd_addr,
  input logic [DW-1:0]  rd_data
);
  localparam int WORDS = 3 * FRAMES / 2;

  AST_CNT_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    int'(frame_cnt) < FRAMES);  // R2

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_evt |=> $stable(fill_sel));  // R3

  AST_SWAP_SETS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> rdy);  // R4

  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !irq_mask) |-> irq);  // R5

  AST_IRQ_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rdy && !irq_mask));  // R5

  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_clr && !swap_evt) |=> !rdy);  // R6

  AST_ALARM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_any |=> (frame_cnt == '0));  // R7

  AST_ALARM_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_any |-> !swap_evt);  // R7

  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) >= WORDS) |-> (rd_data == '0));  // R9
endmodule

bind sect_chan_pingpong sect_chan_pingpong_chk #(
  .FRAMES(FRAMES), .AW(AW), .FCW(FCW), .DW(2*BW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .alarm_any(alarm_any),
  .swap_evt (swap_evt),
  .fill_sel (fill_sel),
  .frame_cnt(frame_cnt),
  .rdy_clr  (rdy_clr),
  .irq_mask (irq_mask),
  .rdy      (rdy),
  .irq      (irq),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data)
);

// File: tb/sect_chan_pingpong_test.sv
module sect_chan_pingpong_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_stb = 1'b0;
  logic [7:0]  byte_a = '0, byte_b = '0, byte_c = '0;
  logic        alm_sig_loss = 1'b0, alm_frm_loss = 1'b0, alm_frm_err = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        rdy_clr = 1'b0;
  logic        irq_mask = 1'b0;
  logic        rdy, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sect_chan_pingpong uut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .byte_a(byte_a), .byte_b(byte_b), .byte_c(byte_c),
    .alm_sig_loss(alm_sig_loss), .alm_frm_loss(alm_frm_loss),
    .alm_frm_err(alm_frm_err), .rd_addr(rd_addr), .rd_data(rd_data),
    .rdy_clr(rdy_clr), .irq_mask(irq_mask), .rdy(rdy), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [7:0] seed, input int w);
    logic [7:0] hi, lo;
    hi = seed + 8'(2 * w);
    lo = seed + 8'(2 * w + 1);
    return {hi, lo};
  endfunction

  // frames [first, first+count) of a block whose byte k equals seed + k
  task automatic send_frames(input logic [7:0] seed, input int first, input int count);
    for (int f = first; f < first + count; f++) begin
      @(negedge clk);
      frame_stb = 1'b1;
      byte_a = seed + 8'(3 * f);
      byte_b = seed + 8'(3 * f + 1);
      byte_c = seed + 8'(3 * f + 2);
      @(negedge clk);
      frame_stb = 1'b0;
    end
  endtask

  task automatic read_word(input int addr, output logic [15:0] d);
    rd_addr = 6'(addr);
    #1;
    d = rd_data;
  endtask

  task automatic clear_rdy();
    @(negedge clk);
    rdy_clr = 1'b1;
    @(negedge clk);
    rdy_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 rdy after reset", 16'(rdy), 16'h0);
    check("R8 irq after reset", 16'(irq), 16'h0);
  endtask

  task automatic t_first_block();
    logic [15:0] d;
    int bad;
    send_frames(8'h10, 0, 23);
    check("R2 rdy after 23 frames", 16'(rdy), 16'h0);
    send_frames(8'h10, 23, 1);
    check("R4 rdy after 24th frame", 16'(rdy), 16'h1);
    check("R5 irq unmasked", 16'(irq), 16'h1);
    read_word(0, d);  check("R1 word0", d, 16'h1011);
    read_word(1, d);  check("R1 word1", d, 16'h1213);
    read_word(2, d);  check("R1 word2", d, 16'h1415);
    read_word(35, d); check("R1 word35", d, exp_word(8'h10, 35));
    bad = 0;
    for (int w = 0; w < 36; w++) begin
      read_word(w, d);
      if (d !== exp_word(8'h10, w)) bad++;
    end
    check("R1 whole bank mismatches", 16'(bad), 16'h0);
  endtask

  task automatic t_isolation();
    logic [15:0] d;
    send_frames(8'h80, 0, 10);
    read_word(0, d);
    check("R3 word0 unchanged while filling", d, 16'h1011);
    read_word(14, d);
    check("R3 word14 unchanged while filling", d, exp_word(8'h10, 14));
    @(negedge clk); irq_mask = 1'b1; #1;
    check("R5 irq masked", 16'(irq), 16'h0);
    check("R5 rdy still set under mask", 16'(rdy), 16'h1);
    irq_mask = 1'b0; #1;
    check("R5 irq unmasked again", 16'(irq), 16'h1);
    clear_rdy();
    check("R6 rdy cleared", 16'(rdy), 16'h0);
    check("R6 irq cleared", 16'(irq), 16'h0);
  endtask

  task automatic t_alarm(input int which, input logic [7:0] seed);
    logic [15:0] d;
    clear_rdy();
    send_frames(8'hC0, 0, 7);
    @(negedge clk);
    case (which)
      0: alm_sig_loss = 1'b1;
      1: alm_frm_loss = 1'b1;
      default: alm_frm_err = 1'b1;
    endcase
    send_frames(8'hE0, 0, 3);
    @(negedge clk);
    alm_sig_loss = 1'b0; alm_frm_loss = 1'b0; alm_frm_err = 1'b0;
    send_frames(seed, 0, 17);
    check("R7 no swap from discarded frames", 16'(rdy), 16'h0);
    send_frames(seed, 17, 6);
    check("R7 rdy after 23 fresh frames", 16'(rdy), 16'h0);
    send_frames(seed, 23, 1);
    check("R7 rdy after 24 fresh frames", 16'(rdy), 16'h1);
    read_word(0, d);  check("R7 word0 fresh block", d, exp_word(seed, 0));
    read_word(35, d); check("R7 word35 fresh block", d, exp_word(seed, 35));
  endtask

  task automatic t_coincide();
    clear_rdy();
    send_frames(8'h55, 0, 23);
    @(negedge clk);
    frame_stb = 1'b1; rdy_clr = 1'b1;
    byte_a = 8'h55 + 8'd69; byte_b = 8'h55 + 8'd70; byte_c = 8'h55 + 8'd71;
    @(negedge clk);
    frame_stb = 1'b0; rdy_clr = 1'b0;
    check("R6 set wins over clear", 16'(rdy), 16'h1);
  endtask

  task automatic t_out_of_range();
    logic [15:0] d;
    read_word(36, d); check("R9 addr 36", d, 16'h0);
    read_word(63, d); check("R9 addr 63", d, 16'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_block();
    t_isolation();
    t_alarm(0, 8'h20);
    t_alarm(1, 8'h31);
    t_alarm(2, 8'h47);
    t_coincide();
    t_out_of_range();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end
endmodule